// File: doc/BRIEF.md
# SPI Shift Engine with Simplex Modes

This block is an SPI serial engine that can drive a bus as master or answer on it as slave. It moves 8-bit words, most significant bit first, with the clock idling low. Data is captured on the rising SCK edge and changed on the falling edge. The parallel side has a one-word transmit holding register, a receive data register with a not-empty flag and an overrun flag, a transmit-empty flag and a busy flag. Each driven pin has its own output-enable, so a released pin can be reused by other logic.

Two control bits choose the mode. With the receive-only bit clear, the engine runs full-duplex. Transmit-only use is the same mode, with the host ignoring what arrives. With the receive-only bit set, the data output pin is released. A receive-only master then produces word after word on its own, without waiting for any transmit write. Clearing the enable bit or the receive-only bit never cuts a word short. The word in flight is finished and stored before SCK settles low, and software polls the busy flag to see that the stop has taken effect.

The master SCK half-period is 2^cfg_div system clocks, so SCK runs at clk / 2^(cfg_div+1). In slave mode the SCK, select and MOSI inputs pass through two-stage synchronizers before edge detection.

Top module: `spi_simplex_engine`

## Requirements
- R1: After reset, busy, rx_ne and rx_ovr are 0 and tx_empty is 1. With cfg_en low, the output-enables sck_oe, mosi_oe, miso_oe and nss_oe are all 0.
- R2: As master with cfg_rxonly=0, a tx_wr while idle makes busy and the select output (nss_o low) go active one cycle later, and tx_empty returns to 1 at that same edge. The written word goes out on mosi_o MSB first, with a new bit after each falling SCK edge.
- R3: When a word completes, it is copied to rx_data and rx_ne is set. A rx_rd pulse clears rx_ne and rx_ovr at the next edge.
- R4: As master, SCK is low whenever busy is low. The first rising edge comes 2^cfg_div cycles after busy rises, and each word takes 16 half-periods. If the transmit register is refilled before a word ends, the next word follows with no idle cycle.
- R5: As master with cfg_rxonly=1, mosi_oe is 0 and words are clocked back to back for as long as cfg_en stays 1, with no tx_wr needed.
- R6: If a word completes while rx_ne is still set and no read is made in that cycle, rx_ovr is set and rx_data takes the newer word.
- R7: Clearing cfg_rxonly or cfg_en during a master word lets that word finish with all 8 rising edges. The word is stored in rx_data, and then busy falls and SCK stays low. sck_oe stays 1 until busy falls.
- R8: As slave with nss_i low, the engine captures mosi_i on each rising sck_i edge and drives the transmit word MSB first on miso_o, changing after each falling edge, with miso_oe=1.
- R9: As slave with cfg_rxonly=1, miso_oe stays 0 and successive words keep being received for as long as nss_i stays low.
- R10: As slave with nss_i high, sck_i and mosi_i activity has no effect: rx_ne stays 0, miso_oe stays 0, and the next selected word is received whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Engine enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_rxonly | input | 1 | Receive-only select |
| cfg_div | input | DIVW | SCK half-period exponent (master) |
| tx_data | input | DW | Word to transmit |
| tx_wr | input | 1 | Write tx_data into the holding register |
| tx_empty | output | 1 | Holding register free |
| rx_data | output | DW | Last received word |
| rx_rd | input | 1 | Read strobe for rx_data |
| rx_ne | output | 1 | Receive register holds an unread word |
| rx_ovr | output | 1 | A word was overwritten before being read |
| busy | output | 1 | Word in progress |
| sck_o | output | 1 | Master SCK output |
| sck_oe | output | 1 | SCK output-enable |
| sck_i | input | 1 | Slave SCK input |
| mosi_o | output | 1 | Master data output |
| mosi_oe | output | 1 | MOSI output-enable |
| mosi_i | input | 1 | Slave data input |
| miso_o | output | 1 | Slave data output |
| miso_oe | output | 1 | MISO output-enable |
| miso_i | input | 1 | Master data input |
| nss_o | output | 1 | Master select output, active low |
| nss_oe | output | 1 | Select output-enable |
| nss_i | input | 1 | Slave select input, active low |

## Verification
In master mode a word starts one edge after the write, or one edge after the previous word ends. SCK toggles every 2^cfg_div edges after that. rx_ne and rx_data change at the edge of the 15th half-period, and busy falls at the 16th. A bench model steps on the same edges as the design and is compared at every falling clock edge, so each of these results is checked in exactly the cycle it is due. Slave results pass through three register stages from the pins. The bench therefore holds each sck_i level for four cycles and reads rx_data, rx_ne and miso_o only after that settling time.

// File: rtl/spi_simplex_engine.sv
module spi_simplex_engine #(
  parameter int DW   = 8,
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_master,
  input  logic            cfg_rxonly,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_wr,
  output logic            tx_empty,
  output logic [DW-1:0]   rx_data,
  input  logic            rx_rd,
  output logic            rx_ne,
  output logic            rx_ovr,
  output logic            busy,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            sck_i,
  output logic            mosi_o,
  output logic            mosi_oe,
  input  logic            mosi_i,
  output logic            miso_o,
  output logic            miso_oe,
  input  logic            miso_i,
  output logic            nss_o,
  output logic            nss_oe,
  input  logic            nss_i
);
  localparam int CW = $clog2(DW + 1);
  localparam int PW = 1 << DIVW;

  logic [DW-1:0] tx_buf, sh_tx;
  logic [DW-2:0] sh_rx;
  logic          tx_full, run, run_rxo, sck_q, sck_d;
  logic [CW-1:0] bits;
  logic [PW-1:0] pcnt;
  logic [1:0]    s_sck, s_nss, s_mosi;

  wire [PW-1:0] half  = PW'(1) << cfg_div;
  wire tick   = run && (pcnt == half - PW'(1));
  wire m_rise = tick & ~sck_q;
  wire m_fall = tick & sck_q;
  wire m_go   = cfg_en & cfg_master & (cfg_rxonly | tx_full);
  wire m_end  = m_fall && (bits == CW'(DW));

  wire s_act  = cfg_en & ~cfg_master & ~s_nss[1];
  wire sl_rise = s_act & s_sck[1] & ~sck_d;
  wire sl_fall = s_act & ~s_sck[1] & sck_d;

  wire samp = cfg_master ? m_rise : sl_rise;
  wire sbit = cfg_master ? miso_i : s_mosi[1];
  wire done = samp && (bits == CW'(DW - 1));
  wire m_on = cfg_master & (cfg_en | run);

  assign tx_empty = ~tx_full;
  assign busy     = cfg_master ? run : (s_act && bits != '0);
  assign sck_o    = sck_q;
  assign sck_oe   = m_on;
  assign nss_o    = ~run;
  assign nss_oe   = m_on;
  assign mosi_o   = sh_tx[DW-1];
  assign mosi_oe  = cfg_master & (run ? ~run_rxo : (cfg_en & ~cfg_rxonly));
  assign miso_o   = sh_tx[DW-1];
  assign miso_oe  = s_act & ~cfg_rxonly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck  <= '0;
      s_nss  <= '1;
      s_mosi <= '0;
      sck_d  <= 1'b0;
    end else begin
      s_sck  <= {s_sck[0], sck_i};
      s_nss  <= {s_nss[0], nss_i};
      s_mosi <= {s_mosi[0], mosi_i};
      sck_d  <= s_sck[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      bits    <= '0;
      rx_data <= '0;
      rx_ne   <= 1'b0;
      rx_ovr  <= 1'b0;
      run     <= 1'b0;
      run_rxo <= 1'b0;
      sck_q   <= 1'b0;
      pcnt    <= '0;
    end else begin
      if (rx_rd) begin
        rx_ne  <= 1'b0;
        rx_ovr <= 1'b0;
      end
      if (samp) begin
        sh_rx <= {sh_rx[DW-3:0], sbit};
        bits  <= bits + CW'(1);
      end
      if (done) begin
        rx_data <= {sh_rx, sbit};
        rx_ne   <= 1'b1;
        if (rx_ne && !rx_rd) rx_ovr <= 1'b1;
      end

      if (cfg_master) begin
        if (!run || m_end) begin
          pcnt  <= '0;
          sck_q <= 1'b0;
          run   <= m_go;
          if (m_go) begin
            run_rxo <= cfg_rxonly;
            bits    <= '0;
            sh_tx   <= cfg_rxonly ? '0 : tx_buf;
            if (!cfg_rxonly) tx_full <= 1'b0;
          end
        end else begin
          pcnt <= tick ? '0 : pcnt + PW'(1);
          if (tick) sck_q <= ~sck_q;
          if (m_fall) sh_tx <= sh_tx << 1;
        end
      end else begin
        run   <= 1'b0;
        sck_q <= 1'b0;
        pcnt  <= '0;
        if (!s_act || done) bits <= '0;
        if (sl_fall && bits != '0) sh_tx <= sh_tx << 1;
        if (bits == '0 && tx_full && !sl_fall) begin
          sh_tx   <= tx_buf;
          tx_full <= 1'b0;
        end
      end

      if (tx_wr) begin
        tx_buf  <= tx_data;
        tx_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_simplex_chk.sv
module spi_simplex_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_master,
  input logic cfg_rxonly,
  input logic busy,
  input logic sck_o,
  input logic mosi_oe,
  input logic miso_oe,
  input logic rx_rd,
  input logic rx_ne,
  input logic rx_ovr
);
  assert_idle_sck_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !busy) |-> !sck_o);

  assert_master_mosi_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_en && cfg_rxonly && !busy) |-> !mosi_oe);

  assert_slave_miso_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && cfg_rxonly) |-> !miso_oe);

  assert_overrun_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> rx_ne);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_ne && !busy) |=> (!rx_ne && !rx_ovr));
endmodule

bind spi_simplex_engine spi_simplex_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
  .cfg_rxonly(cfg_rxonly), .busy(busy), .sck_o(sck_o), .mosi_oe(mosi_oe),
  .miso_oe(miso_oe), .rx_rd(rx_rd), .rx_ne(rx_ne), .rx_ovr(rx_ovr)
);

// File: tb/spi_simplex_engine_tb.sv
module spi_simplex_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, cfg_master = 0, cfg_rxonly = 0;
  logic [2:0] cfg_div = '0;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_wr = 0, tx_empty, rx_rd = 0, rx_ne, rx_ovr, busy;
  logic sck_o, sck_oe, sck_i = 0, mosi_o, mosi_oe, mosi_i = 0;
  logic miso_o, miso_oe, miso_i = 0, nss_o, nss_oe, nss_i = 1;

  always #2.5 clk = ~clk;

  spi_simplex_engine u_dut (
    .clk, .rst_n, .cfg_en, .cfg_master, .cfg_rxonly, .cfg_div,
    .tx_data, .tx_wr, .tx_empty, .rx_data, .rx_rd, .rx_ne, .rx_ovr, .busy,
    .sck_o, .sck_oe, .sck_i, .mosi_o, .mosi_oe, .mosi_i,
    .miso_o, .miso_oe, .miso_i, .nss_o, .nss_oe, .nss_i
  );

  int errs = 0, checks = 0;
  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // behavioural reference for master mode
  logic [7:0] m_txq[$];
  int m_sent[$];
  bit m_run = 0, m_rxo = 0, m_rxne = 0, m_ovr = 0, mon_on = 0;
  int m_t = 0, m_half = 1, m_frames = 0;
  logic [7:0] m_rxdat = '0, sl_byte = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_rxne = 0; m_ovr = 0; m_txq.delete(); m_sent.delete();
    end else begin
      bit go, old;
      m_half = 1 << cfg_div;
      go = cfg_en && cfg_master && (cfg_rxonly || m_txq.size() > 0);
      old = m_rxne;
      if (rx_rd) begin m_rxne = 0; m_ovr = 0; end
      if (cfg_master) begin
        bit start;
        start = 0;
        if (m_run) begin
          m_t++;
          if (m_t == 15 * m_half) begin
            if (old && !rx_rd) m_ovr = 1;
            m_rxne = 1; m_rxdat = sl_byte;
          end
          if (m_t == 16 * m_half) begin
            m_frames++;
            if (go) start = 1; else m_run = 0;
          end
        end else if (go) start = 1;
        if (start) begin
          m_run = 1; m_t = 0; m_rxo = cfg_rxonly;
          if (!cfg_rxonly) m_sent.push_back(int'(m_txq.pop_front()));
          else m_sent.push_back(-1);
        end
      end
      if (tx_wr && cfg_master) m_txq.push_back(tx_data);
    end
  end

  // bench-side slave for master tests, plus per-cycle compare
  bit sck_prev = 0;
  int sb = 0, rc = 0, rises = 0;
  logic [7:0] cap = '0;
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      bit rise, fall;
      rise = sck_o && !sck_prev;
      fall = !sck_o && sck_prev;
      chk(busy == m_run, "R2 busy", busy, m_run);
      chk(sck_o == (m_run && ((m_t / m_half) % 2 == 1)), "R4 sck", sck_o, 0);
      chk(nss_o == !m_run, "R2 nss_o", nss_o, !m_run);
      chk(tx_empty == (m_txq.size() == 0), "R2 tx_empty", tx_empty, m_txq.size() == 0);
      chk(rx_ne == m_rxne, "R3 rx_ne", rx_ne, m_rxne);
      chk(rx_ovr == m_ovr, "R6 rx_ovr", rx_ovr, m_ovr);
      chk(sck_oe == (cfg_en || m_run), "R7 sck_oe", sck_oe, cfg_en || m_run);
      chk(mosi_oe == (m_run ? !m_rxo : (cfg_en && !cfg_rxonly)), "R5 mosi_oe", mosi_oe, !m_rxo);
      if (m_rxne) chk(rx_data == m_rxdat, "R3 rx_data", rx_data, m_rxdat);
      if (rise) begin
        rises++;
        cap = {cap[6:0], mosi_o};
        rc++;
        if (rc == 8) begin
          int e;
          rc = 0;
          e = (m_sent.size() > 0) ? m_sent.pop_front() : -1;
          if (e >= 0) chk(cap == e[7:0], "R2 mosi word", cap, e);
        end
      end
      if (!busy) sb = 0; else if (fall) sb = (sb + 1) % 8;
      miso_i = sl_byte[7 - sb];
    end
    sck_prev = sck_o;
  end

  task automatic pulse_wr(input logic [7:0] d);
    tx_data = d; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask
  task automatic pulse_rd();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask
  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask
  task automatic sl_xfer(input logic [7:0] b, output logic [7:0] got, inout bit oe_seen);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = b[i];
      repeat (4) @(negedge clk);
      got[i] = miso_o;
      oe_seen |= miso_oe;
      sck_i = 1;
      repeat (4) @(negedge clk);
      sck_i = 0;
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] got;
    bit oe;
    repeat (3) @(negedge clk);
    chk(!busy && !rx_ne && !rx_ovr && tx_empty, "R1 flags", {busy, rx_ne, rx_ovr, tx_empty}, 1);
    chk(!sck_oe && !mosi_oe && !miso_oe && !nss_oe, "R1 oe", {sck_oe, mosi_oe, miso_oe, nss_oe}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3/R4: single full-duplex word, fastest clock
    cfg_master = 1; cfg_en = 1; cfg_div = 0; sl_byte = 8'h3C; mon_on = 1;
    @(negedge clk);
    pulse_wr(8'hA5);
    wait_idle();
    chk(rx_data == 8'h3C && rx_ne, "R3 stored word", rx_data, 8'h3C);
    pulse_rd();
    chk(!rx_ne, "R3 read clears", rx_ne, 0);

    // R4/R6: back-to-back words, no read between
    cfg_div = 2; sl_byte = 8'h81;
    @(negedge clk);
    pulse_wr(8'h5A);
    while (!tx_empty) @(negedge clk);
    pulse_wr(8'hC3);
    wait_idle();
    chk(rx_ovr && rx_data == 8'h81, "R6 overrun", rx_ovr, 1);
    pulse_rd();
    chk(!rx_ovr, "R3 overrun cleared", rx_ovr, 0);

    // R5/R7: receive-only stream stopped by clearing rxonly
    cfg_div = 1; sl_byte = 8'h6B; cfg_rxonly = 1; rises = 0;
    repeat (80) @(negedge clk);
    cfg_rxonly = 0;
    wait_idle();
    chk(rises % 8 == 0 && rises >= 24, "R7 whole words", rises, 24);
    chk(rx_ne && rx_data == 8'h6B, "R7 last word stored", rx_data, 8'h6B);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || sck_o) chk(0, "R7 stays idle", busy, 0);
    end
    pulse_rd();

    // R7: stream stopped by clearing enable
    cfg_rxonly = 1; rises = 0;
    repeat (50) @(negedge clk);
    cfg_en = 0;
    wait_idle();
    chk(rises % 8 == 0 && rises >= 8, "R7 enable stop", rises, 8);
    chk(rx_ne, "R7 enable stop stored", rx_ne, 1);
    pulse_rd();
    cfg_rxonly = 0;
    repeat (3) @(negedge clk);

    // slave tests
    mon_on = 0; cfg_master = 0; cfg_en = 1;
    @(negedge clk);
    pulse_wr(8'h96);
    nss_i = 0; oe = 0;
    repeat (4) @(negedge clk);
    sl_xfer(8'h71, got, oe);
    chk(got == 8'h96, "R8 miso word", got, 8'h96);
    chk(rx_data == 8'h71 && rx_ne, "R8 received", rx_data, 8'h71);
    chk(oe, "R8 miso_oe", oe, 1);
    pulse_rd();
    nss_i = 1;
    repeat (4) @(negedge clk);

    cfg_rxonly = 1; nss_i = 0; oe = 0;
    repeat (4) @(negedge clk);
    sl_xfer(8'h12, got, oe);
    chk(rx_data == 8'h12 && rx_ne, "R9 first word", rx_data, 8'h12);
    pulse_rd();
    sl_xfer(8'h34, got, oe);
    chk(rx_data == 8'h34 && rx_ne, "R9 second word", rx_data, 8'h34);
    chk(!oe, "R9 miso_oe stays low", oe, 0);
    pulse_rd();
    nss_i = 1; cfg_rxonly = 0;
    repeat (4) @(negedge clk);

    oe = 0;
    sl_xfer(8'hA5, got, oe);
    sl_xfer(8'h0F, got, oe);
    chk(!rx_ne, "R10 no word while deselected", rx_ne, 0);
    chk(!oe, "R10 miso_oe low", oe, 0);
    nss_i = 0;
    repeat (4) @(negedge clk);
    sl_xfer(8'hE7, got, oe);
    chk(rx_data == 8'hE7 && rx_ne && !rx_ovr, "R10 next word whole", rx_data, 8'hE7);
    nss_i = 1;
    repeat (4) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule